// File: doc/BRIEF.md
# Temperature Conversion Mode Sequencer

This block decides when a temperature conversion runs. It keeps a small configuration register that holds two mode bits and two rate bits. It starts the converter with a one-cycle start pulse and waits for the converter's done pulse, which carries an 8-bit result. It loads that result into a temperature register and sends an end-of-conversion strobe to the limit comparator. In continuous mode it then stays idle for a programmed number of time ticks and converts again. In one-shot mode it converts once and drops back to shutdown. In shutdown mode it does nothing until software asks for work.

A prescaler elsewhere on the chip supplies the time tick. All idle times are counted in those ticks. For each rate code, a parameter gives the start-to-start period in ticks. A second parameter gives the nominal conversion length. The idle time loaded after each result is the period minus the conversion length, with a floor of one tick. The converter handshake is plain pulses: one result per start, with no back-pressure. The block never starts a new conversion while one is still outstanding, so a result can never be lost.

Top module: `tcs_conv_seq`

## Requirements
- R1: While reset is held, mode_o reads 2'b10 (continuous), the rate code is 2'b00 and temp_o reads 0. After reset is released, adc_start_o goes high within four clock cycles.
- R2: adc_start_o is high for exactly one cycle per conversion. No second start is issued while the block still waits for adc_done_i, however long that takes.
- R3: When adc_done_i is sampled while a conversion is outstanding, temp_o takes adc_result_i in the next cycle. In that same cycle eoc_o is high, and only for that one cycle.
- R4: Rate code cfg_rate_i selects period PERIOD_TICKS[code] (code 0 is the slowest). It is sampled when the result is loaded. With tick_i held high, the next adc_start_o appears exactly IDLE+1 cycles after the cycle in which adc_done_i was seen, where IDLE = PERIOD_TICKS[code] - CONV_TICKS.
- R5: The idle count advances only on cycles in which tick_i is high. While tick_i is low, no conversion is started out of the idle wait.
- R6: Mode code 2'b01 (one-shot), written while in shutdown, starts exactly one conversion. mode_o reads 2'b01 while that conversion runs. It reads 2'b00 from the cycle the result is loaded, and no further conversion follows.
- R7: Mode code 2'b00 (shutdown), written while a conversion is running, lets that conversion finish and load its result. After that, no further conversion is started.
- R8: Mode code 2'b00, written during the idle wait of continuous mode, prevents any further conversion.
- R9: A done pulse that arrives while no conversion is outstanding is ignored: eoc_o stays low and temp_o is unchanged.
- R10: A mode code with bit 1 set (continuous), written while in shutdown, starts a conversion within three cycles.
- R11: temp_o reads 0 until the first result is loaded. A one-cycle gc_reset_i pulse returns temp_o to 0 and the configuration to mode 2'b10, rate 2'b00, and a new conversion then starts within four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled time tick, one cycle wide |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 2 | Mode code to write: 00 shutdown, 01 one-shot, 1x continuous |
| cfg_rate_i | input | 2 | Rate code to write; indexes PERIOD_TICKS |
| gc_reset_i | input | 1 | Bus-level general reset request, one cycle |
| adc_start_o | output | 1 | Conversion start pulse |
| adc_done_i | input | 1 | Conversion done pulse |
| adc_result_i | input | 8 | Conversion result, valid with adc_done_i |
| temp_o | output | 8 | Temperature register |
| eoc_o | output | 1 | End-of-conversion strobe to the limit comparator |
| mode_o | output | 2 | Live mode bits for readback |

## Verification
In continuous mode, the start-to-start spacing is measured for every rate code. This separates a wrong table index from an off-by-one in the idle count. A run with the tick held low tells a counter that advances on ticks from one that advances on clocks. Shutdown is requested twice: once during a conversion and once during the idle wait. This shows that a result is still delivered in the first case and that no new start follows in either case. Done pulses are sent with no conversion outstanding, and a conversion is held open with no done. Together these show that results come only from a real handshake and that starts never overlap.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_START,
    ST_WAIT,
    ST_IDLE,
    ST_SHUT
  } seq_st_e;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_ONE  = 2'b01;
  localparam logic [1:0] MODE_RST  = 2'b10;
  localparam logic [1:0] RATE_RST  = 2'b00;

  // Idle ticks after a result; never below one tick.
  function automatic int unsigned idle_of(int unsigned per, int unsigned conv);
    return (per > conv + 1) ? per - conv : 1;
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/tcs_cfg_reg.sv
module tcs_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [1:0] wmode_i,
  input  logic [1:0] wrate_i,
  input  logic       gc_i,
  input  logic       os_clear_i,
  output logic [1:0] mode_o,
  output logic [1:0] rate_o
);
  import tcs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= MODE_RST;
      rate_o <= RATE_RST;
    end else if (gc_i) begin
      mode_o <= MODE_RST;
      rate_o <= RATE_RST;
    end else if (we_i) begin
      mode_o <= wmode_i;
      rate_o <= wrate_i;
    end else if (os_clear_i) begin
      mode_o <= MODE_OFF;
    end
  end

  // R6: a finished one-shot leaves the mode bits at shutdown
  p_oneshot_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (os_clear_i && !we_i && !gc_i) |=> (mode_o == MODE_OFF));

endmodule

// File: rtl/tcs_idle_timer.sv
module tcs_idle_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (load_i)                        cnt_q <= load_val_i;
    else if (run_i && tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && tick_i && (cnt_q == CW'(1));

  // R5: no tick, no progress
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i && !load_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/tcs_seq_fsm.sv
module tcs_seq_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                gc_i,
  input  logic                expire_i,
  input  logic                adc_done_i,
  output tcs_pkg::seq_st_e    st_o,
  output logic                adc_start_o,
  output logic                capture_o,
  output logic                load_o,
  output logic                os_clear_o
);
  import tcs_pkg::*;

  seq_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    capture_o  = 1'b0;
    load_o     = 1'b0;
    os_clear_o = 1'b0;
    case (st_q)
      ST_BOOT:  st_d = ST_START;
      ST_START: st_d = ST_WAIT;
      ST_WAIT: begin
        if (adc_done_i) begin
          capture_o  = 1'b1;
          load_o     = mode_i[1];
          os_clear_o = (mode_i == MODE_ONE);
          st_d       = mode_i[1] ? ST_IDLE : ST_SHUT;
        end
      end
      ST_IDLE: begin
        if (mode_i == MODE_OFF)      st_d = ST_SHUT;
        else if (mode_i == MODE_ONE) st_d = ST_START;
        else if (expire_i)           st_d = ST_START;
      end
      ST_SHUT: begin
        if (mode_i != MODE_OFF) st_d = ST_START;
      end
      default: st_d = ST_BOOT;
    endcase
    if (gc_i) st_d = ST_BOOT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_BOOT;
    else        st_q <= st_d;
  end

  assign st_o        = st_q;
  assign adc_start_o = (st_q == ST_START);

  // R2: start is a single-cycle pulse
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o);

endmodule

// File: rtl/tcs_conv_seq.sv
module tcs_conv_seq #(
  parameter int unsigned PERIOD_TICKS [4] = '{4000, 1000, 250, 125},
  parameter int unsigned CONV_TICKS       = 26,
  parameter int unsigned TW               = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic [1:0]    cfg_rate_i,
  input  logic          gc_reset_i,
  output logic          adc_start_o,
  input  logic          adc_done_i,
  input  logic [TW-1:0] adc_result_i,
  output logic [TW-1:0] temp_o,
  output logic          eoc_o,
  output logic [1:0]    mode_o
);
  import tcs_pkg::*;

  localparam int unsigned PMAX = max4(PERIOD_TICKS[0], PERIOD_TICKS[1],
                                      PERIOD_TICKS[2], PERIOD_TICKS[3]);
  localparam int unsigned CW   = $clog2(PMAX + 1);

  logic [1:0]    rate;
  logic          capture, load, os_clear, expire;
  seq_st_e       st;
  logic [CW-1:0] idle_tab [4];

  for (genvar r = 0; r < 4; r++) begin : g_idle
    assign idle_tab[r] = CW'(idle_of(PERIOD_TICKS[r], CONV_TICKS));
  end

  tcs_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (cfg_we_i),
    .wmode_i    (cfg_mode_i),
    .wrate_i    (cfg_rate_i),
    .gc_i       (gc_reset_i),
    .os_clear_i (os_clear),
    .mode_o     (mode_o),
    .rate_o     (rate)
  );

  tcs_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_o),
    .gc_i        (gc_reset_i),
    .expire_i    (expire),
    .adc_done_i  (adc_done_i),
    .st_o        (st),
    .adc_start_o (adc_start_o),
    .capture_o   (capture),
    .load_o      (load),
    .os_clear_o  (os_clear)
  );

  tcs_idle_timer #(.CW(CW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (idle_tab[rate]),
    .run_i      (st == ST_IDLE),
    .tick_i     (tick_i),
    .expire_o   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_o <= '0;
      eoc_o  <= 1'b0;
    end else if (gc_reset_i) begin
      temp_o <= '0;
      eoc_o  <= 1'b0;
    end else begin
      eoc_o <= capture;
      if (capture) temp_o <= adc_result_i;
    end
  end

  // R3: a strobe only follows a done pulse
  p_eoc_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> $past(adc_done_i));

  // R9: done with nothing outstanding yields no strobe
  p_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done_i && st != ST_WAIT) |=> !eoc_o);

  // R11: temperature only moves with a strobe or a general reset
  p_temp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_o |-> ($stable(temp_o) || $past(gc_reset_i)));

endmodule

// File: tb/tcs_conv_seq_tb.sv
module tcs_conv_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CONV       = 3;
  localparam int ADC_LAT    = 4;
  localparam int unsigned PER [4] = '{40, 20, 12, 8};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [1:0] cfg_rate = 2'b00;
  logic       gc = 1'b0;
  logic       adc_start;
  logic       model_done = 1'b0;
  logic       man_done = 1'b0;
  logic       adc_auto = 1'b1;
  logic       adc_done;
  logic [7:0] adc_result = 8'h00;
  logic [7:0] temp;
  logic       eoc;
  logic [1:0] mode;
  int         lat_cnt = 0;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign adc_done = model_done | man_done;

  // fixed-latency converter model
  always @(negedge clk) begin
    model_done <= 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) model_done <= 1'b1;
    end
    if (adc_start && adc_auto) lat_cnt <= ADC_LAT;
  end

  tcs_conv_seq #(.PERIOD_TICKS(PER), .CONV_TICKS(CONV), .TW(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .cfg_we_i     (cfg_we),
    .cfg_mode_i   (cfg_mode),
    .cfg_rate_i   (cfg_rate),
    .gc_reset_i   (gc),
    .adc_start_o  (adc_start),
    .adc_done_i   (adc_done),
    .adc_result_i (adc_result),
    .temp_o       (temp),
    .eoc_o        (eoc),
    .mode_o       (mode)
  );

  function automatic int idle_exp(int r);
    return int'(PER[r]) - CONV;
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] m, input logic [1:0] r);
    cfg_mode = m;
    cfg_rate = r;
    cfg_we   = 1'b1;
    step();
    cfg_we   = 1'b0;
  endtask

  task automatic wait_start(output int n, input int lim);
    n = 0;
    while (!adc_start && n < lim) begin
      step();
      n++;
    end
  endtask

  task automatic wait_done(input int lim);
    int k = 0;
    while (!adc_done && k < lim) begin
      step();
      k++;
    end
  endtask

  task automatic count_starts(output int c, input int win);
    c = 0;
    for (int i = 0; i < win; i++) begin
      step();
      if (adc_start) c++;
    end
  endtask

  task automatic t_reset();
    int n;
    step();
    check(mode == 2'b10, "R1 reset mode", mode, 2);
    check(temp == 8'h00, "R1 reset temp", temp, 0);
    rst_n = 1'b1;
    wait_start(n, 4);
    check(adc_start == 1'b1, "R1 start after reset", adc_start, 1);
  endtask

  task automatic t_first();
    adc_result = 8'h19;
    step();
    check(adc_start == 1'b0, "R2 start width", adc_start, 0);
    check(temp == 8'h00, "R11 temp before first result", temp, 0);
    wait_done(50);
    step();
    check(eoc == 1'b1, "R3 eoc high", eoc, 1);
    check(temp == 8'h19, "R3 temp loaded", temp, 8'h19);
    step();
    check(eoc == 1'b0, "R3 eoc one cycle", eoc, 0);
  endtask

  task automatic t_rates();
    int n;
    for (int r = 0; r < 4; r++) begin
      cfg_write(2'b10, 2'(r));
      wait_done(200);
      wait_start(n, 500);
      check(n == idle_exp(r) + 1, "R4 start spacing", n, idle_exp(r) + 1);
    end
  endtask

  task automatic t_tick();
    int n;
    int c = 0;
    cfg_write(2'b10, 2'b11);
    wait_done(200);
    tick = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step();
      if (adc_start) c++;
    end
    tick = 1'b1;
    check(c == 0, "R5 no start without tick", c, 0);
    wait_start(n, 200);
    check(n == idle_exp(3), "R5 spacing after stall", n, idle_exp(3));
  endtask

  task automatic t_stop_conv();
    int n;
    int c;
    adc_result = 8'h2A;
    wait_start(n, 200);
    step();
    cfg_write(2'b00, 2'b11);
    wait_done(50);
    step();
    check(eoc == 1'b1 && temp == 8'h2A, "R7 last result delivered", temp, 8'h2A);
    check(mode == 2'b00, "R7 mode off", mode, 0);
    count_starts(c, 100);
    check(c == 0, "R7 no start after shutdown", c, 0);
  endtask

  task automatic t_stray();
    man_done = 1'b1;
    step();
    man_done = 1'b0;
    check(eoc == 1'b0, "R9 stray done no eoc", eoc, 0);
    step();
    check(temp == 8'h2A, "R9 temp unchanged", temp, 8'h2A);
  endtask

  task automatic t_oneshot();
    int n;
    int c;
    adc_result = 8'h7F;
    cfg_write(2'b01, 2'b11);
    wait_start(n, 5);
    check(adc_start == 1'b1, "R6 one-shot starts", adc_start, 1);
    step();
    check(mode == 2'b01, "R6 mode during conversion", mode, 1);
    wait_done(50);
    step();
    check(temp == 8'h7F, "R6 one-shot result", temp, 8'h7F);
    check(mode == 2'b00, "R6 mode after conversion", mode, 0);
    count_starts(c, 100);
    check(c == 0, "R6 single conversion", c, 0);
  endtask

  task automatic t_stall();
    int n;
    int c;
    adc_auto = 1'b0;
    cfg_write(2'b10, 2'b11);
    wait_start(n, 3);
    check(adc_start == 1'b1, "R10 resume from shutdown", adc_start, 1);
    count_starts(c, 60);
    check(c == 0, "R2 no overlapping start", c, 0);
    adc_result = 8'h55;
    man_done = 1'b1;
    step();
    man_done = 1'b0;
    check(eoc == 1'b1 && temp == 8'h55, "R3 late done loads", temp, 8'h55);
    adc_auto = 1'b1;
  endtask

  task automatic t_stop_idle();
    int c;
    wait_done(200);
    step();
    cfg_write(2'b00, 2'b11);
    count_starts(c, 100);
    check(c == 0, "R8 no start after idle shutdown", c, 0);
    check(mode == 2'b00, "R8 mode off", mode, 0);
  endtask

  task automatic t_gc();
    int n;
    adc_result = 8'h33;
    cfg_write(2'b10, 2'b01);
    wait_done(200);
    step();
    check(temp == 8'h33, "R11 value before reset", temp, 8'h33);
    gc = 1'b1;
    step();
    gc = 1'b0;
    check(temp == 8'h00, "R11 temp cleared", temp, 0);
    check(mode == 2'b10, "R11 mode restored", mode, 2);
    wait_start(n, 4);
    check(adc_start == 1'b1, "R11 conversion restarts", adc_start, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_first();
    t_rates();
    t_tick();
    t_stop_conv();
    t_stray();
    t_oneshot();
    t_stall();
    t_stop_idle();
    t_gc();
    repeat (5) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule